// File: doc/BRIEF.md
# ADC Start Event Timing Controller

This block decides when an analog-to-digital converter starts a conversion. It merges three sources of start events into one pulse stream: a host command, a programmable periodic timer clocked by the base clock, and an asynchronous digital trigger pin. Each start event leaves the block as a pulse exactly one clock wide on `start_pulse`. Two status outputs report whether the block is waiting for a trigger edge (`armed`) or is producing timed events (`running`).

A host control write carries a go/stop bit. Two settings choose what a go write does: the rate divisor and the external-trigger enable. With a zero divisor the write fires a single event. With a nonzero divisor and the trigger disabled, the write fires one event at once and then one every `rate_div` base-clock cycles, so the event rate is the base clock frequency divided by the divisor. With a nonzero divisor and the trigger enabled, the write only arms the block. The first selected edge on the trigger pin then fires an event and starts the timer. Separately, the external-start enable makes every selected trigger edge fire one event of its own. A stop write ends timing and disarms the block.

The control is a three-state machine. `ST_IDLE` means no timing is active. `ST_ARMED` means the block waits for an edge. `ST_RUN` means periodic timing is active. These are the transitions:
- IDLE→RUN, ARMED→RUN and RUN→RUN on a go write with nonzero divisor and trigger disabled.
- IDLE→ARMED and RUN→ARMED on a go write with nonzero divisor and trigger enabled.
- ARMED→RUN on a selected edge.
- Any state→IDLE on a stop write, on a go write with zero divisor, or on reset.

Top module: `adc_start_timer`

## Requirements
- R1: With `rate_div` = 0, a control write with `ctl_go` = 1 produces exactly one start pulse, in the cycle after the write is sampled. `running` and `armed` stay 0.
- R2: With `rate_div` ≠ 0 and `trig_en` = 0, a go write produces a pulse in the cycle after the write and sets `running`. Further pulses then follow every `rate_div` clock cycles.
- R3: With `rate_div` ≠ 0 and `trig_en` = 1, a go write sets `armed` and produces no pulse. The first selected edge on `trig_in` produces a pulse, clears `armed`, sets `running`, and starts the period of R2 from that pulse.
- R4: A control write with `ctl_go` = 0 clears `running` and `armed` and resets the period count. Timed pulses stop, and the next go write starts a fresh full period.
- R5: When `xstart_en` = 1, every selected edge on `trig_in` produces one start pulse, whatever the state.
- R6: `trig_in` passes through a two-flop synchronizer before edge detection. `edge_fall` = 0 selects rising edges and 1 selects falling edges. A pin change applied before clock edge k gives its pulse in the cycle after edge k+2.
- R7: Each start event is a pulse one clock wide. With `rate_div` ≥ 2, timed pulses are separated by low cycles.
- R8: `armed` and `running` are never both 1.
- R9: A synchronous reset (`rst` = 1) leaves `start_pulse`, `armed` and `running` at 0 in the following cycle.
- R10: A go write while running restarts the period: a pulse comes in the next cycle, and the following one comes `rate_div` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Control write strobe, one cycle |
| ctl_go | input | 1 | Go (1) or stop (0) bit of the control write |
| rate_div | input | 32 | Period in base-clock cycles; 0 selects one-shot |
| trig_en | input | 1 | External trigger arms periodic timing |
| xstart_en | input | 1 | Each trigger edge fires a single start |
| edge_fall | input | 1 | Edge polarity: 0 rising, 1 falling |
| trig_in | input | 1 | Asynchronous trigger pin |
| start_pulse | output | 1 | One-cycle start event |
| running | output | 1 | Periodic timing active |
| armed | output | 1 | Waiting for a trigger edge |

## Verification
The bench targets these corner cases:
- A zero divisor. A design that treated it as periodic would keep firing.
- A go write while already running. If the counter were not cleared, the next pulse would come early.
- A write that arrives in the same cycle as a trigger edge.
- A change of polarity between edges, which can create or hide an edge. A design without the two-stage synchronizer would answer a cycle early.
- A stop write. If it left the counter mid-count, the next period after a restart would be short.

A cycle-by-cycle reference, computed from the requirements, is compared on all three outputs.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } run_state_t;
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_hit
);
    localparam int TOTAL = SYNC_STAGES + 1;
    logic [TOTAL-1:0] shreg;
    logic             now_lvl;
    logic             prev_lvl;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[TOTAL-2:0], pin};
    end

    assign now_lvl  = shreg[SYNC_STAGES-1];
    assign prev_lvl = shreg[SYNC_STAGES];

    always_comb begin
        if (fall_sel) edge_hit = prev_lvl & ~now_lvl;
        else          edge_hit = now_lvl & ~prev_lvl;
    end
endmodule

// File: rtl/period_counter.sv
module period_counter #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    input  logic [DIV_W-1:0] period,
    output logic             expire
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    assign last   = period - 1'b1;
    assign expire = enable && (period != '0) && (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst || clear)  cnt <= '0;
        else if (expire)   cnt <= '0;
        else if (enable)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/start_fsm.sv
module start_fsm
    import adc_start_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic             ctl_go,
    input  logic [DIV_W-1:0] rate_div,
    input  logic             trig_en,
    input  logic             edge_hit,
    input  logic             period_done,
    output logic             fire,
    output logic             cnt_clear,
    output run_state_t       state
);
    run_state_t nxt;
    logic       div_zero;

    assign div_zero = (rate_div == '0);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt       = state;
        fire      = 1'b0;
        cnt_clear = 1'b0;
        if (ctl_wr) begin
            cnt_clear = 1'b1;
            if (!ctl_go) begin
                nxt = ST_IDLE;
            end else if (div_zero) begin
                nxt  = ST_IDLE;
                fire = 1'b1;
            end else if (trig_en) begin
                nxt = ST_ARMED;
            end else begin
                nxt  = ST_RUN;
                fire = 1'b1;
            end
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_ARMED: begin
                    if (edge_hit) begin
                        nxt       = ST_RUN;
                        fire      = 1'b1;
                        cnt_clear = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (period_done) fire = 1'b1;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_start_timer.sv
module adc_start_timer
    import adc_start_pkg::*;
#(
    parameter int DIV_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic             ctl_go,
    input  logic [DIV_W-1:0] rate_div,
    input  logic             trig_en,
    input  logic             xstart_en,
    input  logic             edge_fall,
    input  logic             trig_in,
    output logic             start_pulse,
    output logic             running,
    output logic             armed
);
    logic       edge_hit;
    logic       period_done;
    logic       fsm_fire;
    logic       cnt_clear;
    run_state_t state;

    trig_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin      (trig_in),
        .fall_sel (edge_fall),
        .edge_hit (edge_hit)
    );

    period_counter #(.DIV_W(DIV_W)) u_period (
        .clk     (clk),
        .rst     (rst),
        .clear   (cnt_clear),
        .enable  (state == ST_RUN),
        .period  (rate_div),
        .expire  (period_done)
    );

    start_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ctl_wr      (ctl_wr),
        .ctl_go      (ctl_go),
        .rate_div    (rate_div),
        .trig_en     (trig_en),
        .edge_hit    (edge_hit),
        .period_done (period_done),
        .fire        (fsm_fire),
        .cnt_clear   (cnt_clear),
        .state       (state)
    );

    always_ff @(posedge clk) begin
        if (rst) start_pulse <= 1'b0;
        else     start_pulse <= fsm_fire | (xstart_en & edge_hit);
    end

    assign running = (state == ST_RUN);
    assign armed   = (state == ST_ARMED);
endmodule

// File: rtl/adc_start_chk.sv
module adc_start_chk #(
    parameter int DIV_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_wr,
    input logic             ctl_go,
    input logic [DIV_W-1:0] rate_div,
    input logic             trig_en,
    input logic             start_pulse,
    input logic             running,
    input logic             armed
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R9
    always_ff @(posedge clk) begin
        if (rst_q === 1'b1)
            reset_idle_chk: assert (!start_pulse && !armed && !running)
                else $error("outputs active right after reset");
    end

    // R8
    status_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(armed && running));

    // R1
    oneshot_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_go && rate_div == '0) |=> (start_pulse && !running && !armed));

    // R2
    soft_run_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_go && rate_div != '0 && !trig_en) |=> (start_pulse && running));

    // R3
    arm_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_go && rate_div != '0 && trig_en) |=> (armed && !running));

    // R4
    stop_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_go) |=> (!armed && !running));
endmodule

bind adc_start_timer adc_start_chk #(.DIV_W(DIV_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr      (ctl_wr),
    .ctl_go      (ctl_go),
    .rate_div    (rate_div),
    .trig_en     (trig_en),
    .start_pulse (start_pulse),
    .running     (running),
    .armed       (armed)
);

// File: tb/test_adc_start_timer.sv
module test_adc_start_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0, ctl_go = 1'b0;
    logic [31:0] rate_div = 32'd0;
    logic        trig_en = 1'b0, xstart_en = 1'b0, edge_fall = 1'b0, trig_in = 1'b0;
    logic        start_pulse, running, armed;

    int compared = 0;
    int mismatched = 0;
    string tag = "R9";

    always #4 clk = ~clk;

    adc_start_timer i_adc_start_timer (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_go(ctl_go), .rate_div(rate_div),
        .trig_en(trig_en), .xstart_en(xstart_en), .edge_fall(edge_fall), .trig_in(trig_in),
        .start_pulse(start_pulse), .running(running), .armed(armed)
    );

    // reference: mode 0 idle, 1 waiting for edge, 2 timed
    int          m_mode = 0;
    logic [31:0] m_elapsed = 0;
    logic        p1 = 0, p2 = 0, p3 = 0;
    logic        exp_pulse = 0;

    function automatic logic sel_edge(input logic cur, input logic old, input logic fall);
        return fall ? (old && !cur) : (cur && !old);
    endfunction

    always @(posedge clk) begin
        logic hit, fire;
        if (rst) begin
            m_mode = 0; m_elapsed = 0; p1 = 0; p2 = 0; p3 = 0; exp_pulse = 0;
        end else begin
            hit  = sel_edge(p2, p3, edge_fall);
            fire = 1'b0;
            if (ctl_wr) begin
                m_elapsed = 0;
                if (!ctl_go)            m_mode = 0;
                else if (rate_div == 0) begin m_mode = 0; fire = 1'b1; end
                else if (trig_en)       m_mode = 1;
                else                    begin m_mode = 2; fire = 1'b1; end
            end else if (m_mode == 1) begin
                if (hit) begin m_mode = 2; m_elapsed = 0; fire = 1'b1; end
            end else if (m_mode == 2) begin
                if (m_elapsed + 1 == rate_div) begin fire = 1'b1; m_elapsed = 0; end
                else m_elapsed = m_elapsed + 1;
            end
            if (xstart_en && hit) fire = 1'b1;
            exp_pulse = fire;
            p3 = p2; p2 = p1; p1 = trig_in;
        end
    end

    task automatic cmp(input string what, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        cmp("start_pulse", start_pulse, exp_pulse);
        cmp("running(R8)", running, m_mode == 2);
        cmp("armed(R8)", armed, m_mode == 1);
    endtask

    task automatic wr(input logic go);
        ctl_wr = 1'b1; ctl_go = go;
        cyc();
        ctl_wr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R9: reset state
        wait_n(3);
        rst = 1'b0;
        wait_n(2);

        tag = "R1"; rate_div = 0; wr(1'b1); wait_n(8);
        tag = "R2"; rate_div = 5; wr(1'b1); wait_n(17);
        tag = "R10"; wait_n(2); wr(1'b1); wait_n(12);
        tag = "R4"; wr(1'b0); wait_n(8); rate_div = 4; wr(1'b1); wait_n(9); wr(1'b0);
        tag = "R3"; trig_en = 1; rate_div = 3; wr(1'b1); wait_n(6);
        trig_in = 1; wait_n(12); trig_in = 0; wait_n(4); wr(1'b0);
        tag = "R6"; edge_fall = 1; trig_in = 1; wait_n(4); wr(1'b1); wait_n(3);
        trig_in = 0; wait_n(10); wr(1'b0); edge_fall = 0; trig_en = 0;
        tag = "R5"; xstart_en = 1; wait_n(3);
        for (int k = 0; k < 4; k++) begin trig_in = ~trig_in; wait_n(3); end
        xstart_en = 0;
        tag = "R9"; rate_div = 2; wr(1'b1); wait_n(3); rst = 1; wait_n(2); rst = 0; wait_n(3);

        // R7 and mixed modes: random stimulus with fixed seed
        tag = "R7";
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 4000; n++) begin
            ctl_wr = 1'b0;
            if (($urandom % 100) < 6) begin ctl_wr = 1'b1; ctl_go = (($urandom % 10) < 7); end
            if (m_mode == 0 && !ctl_wr && ($urandom % 100) < 5) begin
                int r; r = $urandom % 9;
                rate_div = (r == 0) ? 32'd0 : 32'(r + 1);
            end
            if (($urandom % 100) < 3) trig_en   = $urandom % 2;
            if (($urandom % 100) < 3) xstart_en = $urandom % 2;
            if (($urandom % 100) < 2) edge_fall = $urandom % 2;
            if (($urandom % 100) < 10) trig_in  = ~trig_in;
            if (ctl_wr && ctl_go && rate_div != 0 && !trig_en) trig_en = trig_en;
            cyc();
        end
        ctl_wr = 1'b0;
        wait_n(4);
        summary();
    end
endmodule